// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and the pins of a 24-bit parallel panel bus. Each pixel-clock cycle it accepts one 24-bit RGB pixel together with horizontal sync, vertical sync and data-enable. The three colour channels can be reordered, and the result is then packed into one of several bus layouts: full 8/8/8, two 6/6/6 layouts or three 5/6/5 layouts, each with its own zero padding. Every control signal can be inverted, launched half a cycle late from the falling clock edge, or forced to its idle level.

All settings live in one 17-bit control word. A small memory-mapped read/write port reaches it at address 0. A read from any other address returns the fixed identification word 0x00647069, and a write to any other address does nothing. Bit 0 of the control word gates the whole output path. While it is clear the bus and control pins rest at zero, and setting it starts the output path again from a cleared state.

Top module: `rgb_bus_fmt`

## Requirements
- R1: Control bits [15:14] choose the channel order, with input R in [23:16], G in [15:8] and B in [7:0]. The value 0 sends R,G,B to the first, second and third packed slots. The value 1 sends B,G,R, the value 2 sends G,R,B and the value 3 sends B,R,G.
- R2: Control bits [13:11] choose the packing of slots s0,s1,s2, listed from MSB to LSB. A 5- or 6-bit field keeps the top bits of its channel.
  - 0 and 7: all zeros.
  - 1: {8 zeros, s0[7:3], s1[7:2], s2[7:3]}.
  - 2: {3 zeros, s0[7:3], 2 zeros, s1[7:2], 3 zeros, s2[7:3]}.
  - 3: {2 zeros, s0[7:3], 3 zeros, s1[7:2], 2 zeros, s2[7:3], 1 zero}.
  - 4: {6 zeros, s0[7:2], s1[7:2], s2[7:2]}.
  - 5: {2 zeros, s0[7:2], 2 zeros, s1[7:2], 2 zeros, s2[7:2]}.
  - 6: {s0, s1, s2}.
- R3: A pixel sampled on rising edge N appears on the bus after edge N and holds until edge N+1, which is one cycle of latency.
- R4: Control bits 6, 5 and 4 move hsync, vsync and data-enable respectively to a falling-edge launch. The pin then changes half a cycle later than it would on the rising-edge path.
- R5: Control bits 9, 8 and 7 invert hsync, vsync and data-enable. Bits 3, 2 and 1 disable them. A disabled pin rests at the value of its invert bit, which is the idle level of the chosen polarity.
- R6: Bit 10 inverts the pixel clock output: pclk_out equals clk XOR bit 10 while the block is enabled.
- R7: While bit 0 is 0, bus_out, hs_out, vs_out, de_out and pclk_out are 0 from the next clock boundary on. Setting bit 0 restarts from cleared registers, so the first cycle afterwards shows the newly sampled pixel.
- R8: The control word resets to 0. A write to address 0 stores wdata[16:0], which becomes visible on a read and takes effect at the next rising edge. Bit 16 (output-enable mode) is stored and read back.
- R9: A read from any address other than 0 returns 0x00647069. A write to such an address leaves the control word and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| pix_in | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| hs_in | input | 1 | Horizontal sync from the timing generator |
| vs_in | input | 1 | Vertical sync from the timing generator |
| de_in | input | 1 | Data-enable from the timing generator |
| pclk_out | output | 1 | Conditioned pixel clock to the panel |
| bus_out | output | 24 | Packed parallel data bus |
| hs_out | output | 1 | Conditioned horizontal sync |
| vs_out | output | 1 | Conditioned vertical sync |
| de_out | output | 1 | Conditioned data-enable |

## Verification
Bus data and rising-launched control pins are due one rising edge after the inputs are driven. The bench drives every input on a falling edge and samples 2 ns after the next rising edge. Falling-launched pins are due half a cycle later, so they are sampled 6 ns after the rising edge; a second sample at 2 ns shows that the old level is still held. Register writes are committed on the rising edge between two falling edges, so readback, the disable and re-enable behaviour are checked at the first sample point after that edge.

// File: rtl/rgb_fmt_pkg.sv
`timescale 1ns/1ps
package rgb_fmt_pkg;

    localparam int CH_W    = 8;
    localparam int PIX_W   = 3 * CH_W;
    localparam int CFG_W   = 17;
    localparam int N_SYNC  = 3;
    localparam int DATA_W  = 32;

    typedef enum logic [1:0] {
        ORD_RGB = 2'd0,
        ORD_BGR = 2'd1,
        ORD_GRB = 2'd2,
        ORD_BRG = 2'd3
    } chan_order_e;

    typedef enum logic [2:0] {
        PK_ZERO       = 3'd0,
        PK_565_LOW    = 3'd1,
        PK_565_SPREAD = 3'd2,
        PK_565_SHIFT  = 3'd3,
        PK_666_LOW    = 3'd4,
        PK_666_SPREAD = 3'd5,
        PK_888        = 3'd6,
        PK_RSVD       = 3'd7
    } pack_e;

    // Sync vectors are ordered {hsync, vsync, data-enable}.
    typedef struct packed {
        logic              oe_mode;   // bit 16
        chan_order_e       order;     // bits 15:14
        pack_e             pack;      // bits 13:11
        logic              pclk_inv;  // bit 10
        logic [N_SYNC-1:0] inv;       // bits 9:7
        logic [N_SYNC-1:0] fall;      // bits 6:4
        logic [N_SYNC-1:0] off;       // bits 3:1
        logic              en;        // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [CH_W-1:0] s0;
        logic [CH_W-1:0] s1;
        logic [CH_W-1:0] s2;
    } trio_t;

    function automatic trio_t shuffle(input logic [PIX_W-1:0] px,
                                      input chan_order_e ord);
        logic [CH_W-1:0] r, g, b;
        trio_t t;
        r = px[3*CH_W-1:2*CH_W];
        g = px[2*CH_W-1:CH_W];
        b = px[CH_W-1:0];
        case (ord)
            ORD_BGR: begin t.s0 = b; t.s1 = g; t.s2 = r; end
            ORD_GRB: begin t.s0 = g; t.s1 = r; t.s2 = b; end
            ORD_BRG: begin t.s0 = b; t.s1 = r; t.s2 = g; end
            default: begin t.s0 = r; t.s1 = g; t.s2 = b; end
        endcase
        return t;
    endfunction

    function automatic logic [PIX_W-1:0] pack_bus(input trio_t t,
                                                  input pack_e mode);
        logic [PIX_W-1:0] v;
        case (mode)
            PK_565_LOW:    v = {8'b0, t.s0[CH_W-1 -: 5], t.s1[CH_W-1 -: 6],
                                t.s2[CH_W-1 -: 5]};
            PK_565_SPREAD: v = {3'b0, t.s0[CH_W-1 -: 5], 2'b0, t.s1[CH_W-1 -: 6],
                                3'b0, t.s2[CH_W-1 -: 5]};
            PK_565_SHIFT:  v = {2'b0, t.s0[CH_W-1 -: 5], 3'b0, t.s1[CH_W-1 -: 6],
                                2'b0, t.s2[CH_W-1 -: 5], 1'b0};
            PK_666_LOW:    v = {6'b0, t.s0[CH_W-1 -: 6], t.s1[CH_W-1 -: 6],
                                t.s2[CH_W-1 -: 6]};
            PK_666_SPREAD: v = {2'b0, t.s0[CH_W-1 -: 6], 2'b0, t.s1[CH_W-1 -: 6],
                                2'b0, t.s2[CH_W-1 -: 6]};
            PK_888:        v = {t.s0, t.s1, t.s2};
            default:       v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rgb_fmt_ctrl_regs.sv
`timescale 1ns/1ps
module rgb_fmt_ctrl_regs
    import rgb_fmt_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          CTRL_ADDR = 0,
    parameter logic [31:0] ID_WORD   = 32'h0064_7069
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl
);
    localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
    localparam int                PAD_W    = DATA_W - CFG_W;

    logic hit;
    logic [PAD_W-1:0] unused_wdata_hi;

    assign hit             = (addr == CTRL_SEL);
    assign unused_wdata_hi = wdata[DATA_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && hit) begin
            ctrl <= ctrl_t'(wdata[CFG_W-1:0]);
        end
    end

    always_comb begin
        if (hit) rdata = {{PAD_W{1'b0}}, ctrl};
        else     rdata = ID_WORD;
    end

    AST_WR_STORES: assert property (@(posedge clk) disable iff (rst)
        (we && hit) |=> (ctrl == ctrl_t'($past(wdata[CFG_W-1:0]))));   // R8
    AST_FOREIGN_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && !hit) |=> $stable(ctrl));                                // R9
    AST_ID_ON_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!hit) |-> (rdata == ID_WORD));                                 // R9

endmodule

// File: rtl/rgb_fmt_pixel_path.sv
`timescale 1ns/1ps
module rgb_fmt_pixel_path
    import rgb_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PIX_W-1:0] pix_in,
    input  chan_order_e      order,
    input  pack_e            pack,
    output logic [PIX_W-1:0] bus_q
);
    trio_t            slots;
    logic [PIX_W-1:0] packed_d;

    always_comb begin
        slots    = shuffle(pix_in, order);
        packed_d = pack_bus(slots, pack);
    end

    always_ff @(posedge clk) begin
        if (clr) bus_q <= '0;
        else     bus_q <= packed_d;
    end

    AST_EMPTY_FORMAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!clr && (pack == PK_ZERO || pack == PK_RSVD)) |=> (bus_q == '0)); // R2
    AST_STRAIGHT_PASS: assert property (@(posedge clk) disable iff (rst)
        (!clr && pack == PK_888 && order == ORD_RGB) |=> (bus_q == $past(pix_in))); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bus_q == '0));                                             // R7

endmodule

// File: rtl/rgb_fmt_sync_cond.sv
`timescale 1ns/1ps
module rgb_fmt_sync_cond (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sig_in,
    input  logic inv,
    input  logic fall,
    input  logic off,
    output logic sig_out
);
    logic lvl_d;
    logic rise_q;
    logic fall_q;

    assign lvl_d = off ? inv : (sig_in ^ inv);

    always_ff @(posedge clk) begin
        if (clr) rise_q <= 1'b0;
        else     rise_q <= lvl_d;
    end

    always_ff @(negedge clk) begin
        if (clr) fall_q <= 1'b0;
        else     fall_q <= rise_q;
    end

    assign sig_out = fall ? fall_q : rise_q;

    AST_OFF_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!clr && off) |=> (rise_q == $past(inv)));          // R5
    AST_INVERT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!clr && !off) |=> (rise_q == ($past(sig_in) ^ $past(inv)))); // R5
    AST_HALF_CYCLE_COPY: assert property (@(posedge clk) disable iff (rst)
        (!clr) |-> (fall_q == rise_q));                     // R4

endmodule

// File: rtl/rgb_bus_fmt.sv
`timescale 1ns/1ps
module rgb_bus_fmt
    import rgb_fmt_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          CTRL_ADDR = 0,
    parameter logic [31:0] ID_WORD   = 32'h0064_7069
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [23:0]       pix_in,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              de_in,
    output logic              pclk_out,
    output logic [23:0]       bus_out,
    output logic              hs_out,
    output logic              vs_out,
    output logic              de_out
);
    ctrl_t             ctrl;
    logic              dp_clr;
    logic [N_SYNC-1:0] sync_in;
    logic [N_SYNC-1:0] sync_out;
    logic              unused_oe_mode;

    rgb_fmt_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .ID_WORD   (ID_WORD)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ctrl  (ctrl)
    );

    assign dp_clr         = rst | ~ctrl.en;
    assign unused_oe_mode = ctrl.oe_mode;

    rgb_fmt_pixel_path pix_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (dp_clr),
        .pix_in (pix_in),
        .order  (ctrl.order),
        .pack   (ctrl.pack),
        .bus_q  (bus_out)
    );

    assign sync_in = {hs_in, vs_in, de_in};

    for (genvar j = 0; j < N_SYNC; j++) begin : g_sync
        rgb_fmt_sync_cond cond_i (
            .clk     (clk),
            .rst     (rst),
            .clr     (dp_clr),
            .sig_in  (sync_in[j]),
            .inv     (ctrl.inv[j]),
            .fall    (ctrl.fall[j]),
            .off     (ctrl.off[j]),
            .sig_out (sync_out[j])
        );
    end

    assign {hs_out, vs_out, de_out} = sync_out;
    assign pclk_out = ctrl.en & (clk ^ ctrl.pclk_inv);

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en) |=> (bus_out == '0 && sync_out == '0));   // R7
    AST_CLOCK_GATED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en) |-> (pclk_out == 1'b0));                 // R7

endmodule

// File: tb/rgb_bus_fmt_tb.sv
`timescale 1ns/1ps
module rgb_bus_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [23:0] pix_in = '0;
    logic [2:0]  s_in = '0;
    logic        pclk_out;
    logic [23:0] bus_out;
    logic        hs_out, vs_out, de_out;
    logic [2:0]  s_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign s_out = {hs_out, vs_out, de_out};

    rgb_bus_fmt dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pix_in    (pix_in),
        .hs_in     (s_in[2]),
        .vs_in     (s_in[1]),
        .de_in     (s_in[0]),
        .pclk_out  (pclk_out),
        .bus_out   (bus_out),
        .hs_out    (hs_out),
        .vs_out    (vs_out),
        .de_out    (de_out)
    );

    localparam logic [31:0] ID_EXP = 32'h0064_7069;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input int ord, input int fmt, input bit pinv,
                                          input logic [2:0] inv, input logic [2:0] fall,
                                          input logic [2:0] off, input bit en);
        return (32'd1 << 16) | (32'(ord) << 14) | (32'(fmt) << 11) | (32'(pinv) << 10)
             | (32'(inv) << 7) | (32'(fall) << 4) | (32'(off) << 1) | 32'(en);
    endfunction

    function automatic logic [23:0] ref_bus(input logic [23:0] px, input int ord, input int fmt);
        int r, g, b, c0, c1, c2, w0, w1, w2, sh0, sh1, sh2;
        r = int'(px[23:16]); g = int'(px[15:8]); b = int'(px[7:0]);
        case (ord)
            1: begin c0 = b; c1 = g; c2 = r; end
            2: begin c0 = g; c1 = r; c2 = b; end
            3: begin c0 = b; c1 = r; c2 = g; end
            default: begin c0 = r; c1 = g; c2 = b; end
        endcase
        case (fmt)
            1: begin w0 = 5; w1 = 6; w2 = 5; sh0 = 11; sh1 = 5; sh2 = 0; end
            2: begin w0 = 5; w1 = 6; w2 = 5; sh0 = 16; sh1 = 8; sh2 = 0; end
            3: begin w0 = 5; w1 = 6; w2 = 5; sh0 = 17; sh1 = 8; sh2 = 1; end
            4: begin w0 = 6; w1 = 6; w2 = 6; sh0 = 12; sh1 = 6; sh2 = 0; end
            5: begin w0 = 6; w1 = 6; w2 = 6; sh0 = 16; sh1 = 8; sh2 = 0; end
            6: begin w0 = 8; w1 = 8; w2 = 8; sh0 = 16; sh1 = 8; sh2 = 0; end
            default: return 24'h0;
        endcase
        return 24'(((c0 >> (8 - w0)) << sh0) + ((c1 >> (8 - w1)) << sh1)
                 + ((c2 >> (8 - w2)) << sh2));
    endfunction

    // Drives a write on a falling edge; it commits on the following rising
    // edge and the task returns on the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R8, R7)
        cfg_addr = 4'd0;
        #1;
        chk("R8 reset control word", cfg_rdata, 32'h0);
        chk("R7 reset bus", {8'h0, bus_out}, 32'h0);
        chk("R7 reset syncs", {29'h0, s_out}, 32'h0);
        chk("R7 reset pclk", {31'h0, pclk_out}, 32'h0);

        // Channel order and packing sweep (R1, R2)
        for (int ord = 0; ord < 4; ord++) begin
            for (int fmt = 0; fmt < 8; fmt++) begin
                wr(4'd0, mkcfg(ord, fmt, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
                for (int k = 0; k < 4; k++) begin
                    logic [23:0] px;
                    px = (k == 0) ? 24'hFFFFFF : 24'((k * 32'h9E3779 + ord * 32'h2468AC + fmt * 32'h13579B) & 32'hFFFFFF);
                    pix_in = px;
                    @(posedge clk); #2;
                    chk((fmt == 6) ? "R1 order full" : "R2 packing", {8'h0, bus_out},
                        {8'h0, ref_bus(px, ord, fmt)});
                    @(negedge clk);
                end
            end
        end

        // One-cycle latency (R3)
        wr(4'd0, mkcfg(0, 6, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
        pix_in = 24'hA1B2C3;
        @(posedge clk); #2;
        chk("R3 new pixel after edge", {8'h0, bus_out}, 32'h00A1B2C3);
        @(negedge clk);
        pix_in = 24'h5A6B7C;
        #2;
        chk("R3 old pixel held before edge", {8'h0, bus_out}, 32'h00A1B2C3);
        @(posedge clk); #2;
        chk("R3 next pixel", {8'h0, bus_out}, 32'h005A6B7C);
        @(negedge clk);

        // Sync conditioning: invert, disable, falling launch (R4, R5)
        for (int j = 0; j < 3; j++) begin
            for (int c = 0; c < 8; c++) begin
                for (int v = 0; v < 2; v++) begin
                    bit iv, fl, of;
                    logic e_old, e_new;
                    iv = c[0]; fl = c[1]; of = c[2];
                    wr(4'd0, mkcfg(0, 6, 1'b0, 3'(iv) << j, 3'(fl) << j, 3'(of) << j, 1'b1));
                    s_in = 3'(v) << j;
                    @(negedge clk); @(negedge clk);
                    s_in = 3'(!v) << j;
                    e_old = of ? iv : (1'(v) ^ iv);
                    e_new = of ? iv : (1'(!v) ^ iv);
                    @(posedge clk); #2;
                    chk(fl ? "R4 falling launch holds old level" : "R5 rising launch level",
                        {31'h0, s_out[j]}, {31'h0, (fl ? e_old : e_new)});
                    #4;
                    chk(of ? "R5 disabled idle level" : "R5 polarity",
                        {31'h0, s_out[j]}, {31'h0, e_new});
                    @(negedge clk);
                end
            end
        end
        s_in = '0;

        // Pixel clock inversion (R6)
        for (int p = 0; p < 2; p++) begin
            wr(4'd0, mkcfg(0, 6, 1'(p), 3'b000, 3'b000, 3'b000, 1'b1));
            @(posedge clk); #2;
            chk("R6 pclk high phase", {31'h0, pclk_out}, {31'h0, 1'(1 ^ p)});
            #4;
            chk("R6 pclk low phase", {31'h0, pclk_out}, {31'h0, 1'(p)});
            @(negedge clk);
        end

        // Enable gate (R7)
        wr(4'd0, mkcfg(0, 6, 1'b0, 3'b100, 3'b010, 3'b000, 1'b1));
        pix_in = 24'h123456; s_in = 3'b111;
        @(posedge clk); #2;
        chk("R7 enabled bus", {8'h0, bus_out}, 32'h00123456);
        @(negedge clk);
        wr(4'd0, mkcfg(0, 6, 1'b0, 3'b100, 3'b010, 3'b000, 1'b0));
        pix_in = 24'h789ABC; s_in = 3'b011;
        @(posedge clk); #2;
        chk("R7 disabled bus zero", {8'h0, bus_out}, 32'h0);
        chk("R7 disabled pclk low", {31'h0, pclk_out}, 32'h0);
        #4;
        chk("R7 disabled syncs zero", {29'h0, s_out}, 32'h0);
        chk("R7 disabled pclk low phase", {31'h0, pclk_out}, 32'h0);
        @(negedge clk);
        wr(4'd0, mkcfg(0, 6, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
        pix_in = 24'hC0FFEE; s_in = 3'b101;
        @(posedge clk); #2;
        chk("R7 restart first pixel", {8'h0, bus_out}, 32'h00C0FFEE);
        chk("R7 restart syncs", {29'h0, s_out}, 32'h5);
        @(negedge clk);
        s_in = '0;

        // Register port (R8, R9)
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'hFFFF_FFFE;
        #2;
        chk("R8 write not visible before edge", cfg_rdata,
            mkcfg(0, 6, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
        @(posedge clk); #2;
        cfg_we = 1'b0;
        chk("R8 write stores 17 bits incl mode bit", cfg_rdata, 32'h0001_FFFE);
        @(negedge clk);
        wr(4'd0, mkcfg(0, 6, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
        cfg_addr = 4'd1;  #1; chk("R9 id at 1", cfg_rdata, ID_EXP);
        cfg_addr = 4'd7;  #1; chk("R9 id at 7", cfg_rdata, ID_EXP);
        cfg_addr = 4'd15; #1; chk("R9 id at 15", cfg_rdata, ID_EXP);
        cfg_addr = 4'd0;
        wr(4'd9, 32'h0000_0000);
        #1;
        chk("R9 foreign write ignored", cfg_rdata,
            mkcfg(0, 6, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1));
        pix_in = 24'h0F1E2D;
        @(posedge clk); #2;
        chk("R9 output unaffected by foreign write", {8'h0, bus_out}, 32'h000F1E2D);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule